// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block watches the bytes of a 512-byte NAND page as they cross the data path and builds Hamming parity for single-error correction. It splits the page into two 256-byte halves and handles each one separately. For every half it keeps sixteen line-parity bits and six column-parity bits. Software clears the block before the page moves. It then moves the page one byte at a time. When the page is done, it reads the six ECC bytes one at a time through a readout pointer. Finding and fixing the error stays with software.

A byte counts only in a cycle where its valid strobe is high. Stalls and gaps between bytes therefore leave the result unchanged. The readout output is combinational from the accumulators and the pointer. A byte taken at a clock edge shows up at the output right after that edge.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, the six readout bytes are 0x00, 0x00, 0x03, 0x00, 0x00, 0x03, and the pointer is at the first byte.
- R2: Each half's column parity CP[5:0] XOR-accumulates over every accepted byte b of that half:
  - CP0 = b0^b2^b4^b6
  - CP1 = b1^b3^b5^b7
  - CP2 = b0^b1^b4^b5
  - CP3 = b2^b3^b6^b7
  - CP4 = b0^b1^b2^b3
  - CP5 = b4^b5^b6^b7
- R3: For each byte at index j (0..255) within its half, let p be the byte's XOR parity. For k = 0..7, p is XORed into line-parity bit 2k+1 if bit k of j is 1, else into bit 2k. This gives 16 line-parity bits per half.
- R4: Page bytes 0..255 update only the first half, which holds LP[15:0] and CP[5:0]. Page bytes 256..511 update only the second half, which holds LP[31:16] and CP[11:6].
- R5: The readout order is LP[7:0], LP[15:8], {CP[5:0],2'b11}, LP[23:16], LP[31:24], {CP[11:6],2'b11}.
- R6: Each `rd_adv_i` cycle moves the pointer one slot at the next edge. After the sixth slot the pointer wraps to the first.
- R7: Cycles with `byte_vld_i` low change nothing, whatever `byte_i` carries.
- R8: `clr_i` zeroes both halves, the byte count and the pointer. It wins over a byte or a readout advance in the same cycle.
- R9: The two lowest bits of each column-parity readout byte always read as 1.
- R10: The byte count wraps after 512 bytes, so byte 512 folds into the first half at index 0.
- R11: An accepted byte is visible on `ecc_byte_o` in the cycle after the edge that takes it in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Clears the ECC state, the byte count and the pointer |
| byte_vld_i | input | 1 | Marks `byte_i` as a page byte this cycle |
| byte_i | input | 8 | Page data byte |
| rd_adv_i | input | 1 | Advances the readout pointer after the current byte is read |
| ecc_byte_o | output | 8 | ECC byte at the current readout slot |

## Verification
Suppose the byte counter slips or a gap cycle is taken as a byte. The line-parity bytes of the affected half then differ from the model at the first readout after the page, and the column byte may differ as well. A pointer that skips or fails to wrap shows up as the wrong slot on the very next read. This is most visible at the pad bits of the column slots and at the seventh read. A clear that misses a half leaves nonzero bytes in the readout that follows it at once.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CP_W   = 6;

  // Column parity groups of one byte: alternate bits, alternate pairs, nibbles.
  function automatic logic [CP_W-1:0] col_par(input logic [BYTE_W-1:0] b);
    logic [CP_W-1:0] r;
    r[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
    r[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
    r[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
    r[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
    r[4] = ^b[3:0];
    r[5] = ^b[7:4];
    return r;
  endfunction
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [LP_W-1:0]   lp_o,
  output logic [CP_W-1:0]   cp_o
);
  logic [LP_W-1:0] lp_q, lp_d;
  logic [CP_W-1:0] cp_q, cp_d;
  logic            byte_par;

  assign byte_par = ^byte_i;

  always_comb begin
    lp_d = lp_q;
    cp_d = cp_q;
    if (clr_i) begin
      lp_d = '0;
      cp_d = '0;
    end else if (en_i) begin
      for (int k = 0; k < IDX_W; k++) begin
        if (idx_i[k]) lp_d[2*k+1] = lp_q[2*k+1] ^ byte_par;
        else          lp_d[2*k]   = lp_q[2*k]   ^ byte_par;
      end
      cp_d = cp_q ^ col_par(byte_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr_i || en_i) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;
endmodule

// File: rtl/ecc_rd_ptr.sv
module ecc_rd_ptr #(
  parameter int unsigned N_SLOTS = 6,
  localparam int unsigned PTR_W = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)                                ptr_d = '0;
    else if (adv_i && ptr_q == PTR_W'(N_SLOTS-1)) ptr_d = '0;
    else if (adv_i)                           ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (clr_i || adv_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int unsigned HALF_BYTES = 256,
  parameter int unsigned HALVES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_adv_i,
  output logic [BYTE_W-1:0] ecc_byte_o
);
  localparam int unsigned IDX_W    = $clog2(HALF_BYTES);
  localparam int unsigned LP_W     = 2 * IDX_W;
  localparam int unsigned LP_BYTES = LP_W / BYTE_W;
  localparam int unsigned SPH      = LP_BYTES + 1;
  localparam int unsigned N_SLOTS  = HALVES * SPH;
  localparam int unsigned PTR_W    = $clog2(N_SLOTS);
  localparam int unsigned CNT_W    = $clog2(HALF_BYTES * HALVES);
  localparam int unsigned HSEL_W   = CNT_W - IDX_W;

  logic              rst_n_s;
  logic [CNT_W-1:0]  byte_cnt, byte_cnt_d;
  logic [PTR_W-1:0]  rd_ptr;
  logic [LP_W-1:0]   lp_w [HALVES];
  logic [CP_W-1:0]   cp_w [HALVES];
  logic [BYTE_W-1:0] slot [N_SLOTS];

  ecc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Position of the next byte within the page; wraps at the page size.
  always_comb begin
    byte_cnt_d = byte_cnt;
    if (clr_i)           byte_cnt_d = '0;
    else if (byte_vld_i) byte_cnt_d = byte_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)                 byte_cnt <= '0;
    else if (clr_i || byte_vld_i) byte_cnt <= byte_cnt_d;
  end

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic en_h;
      assign en_h = byte_vld_i && (byte_cnt[CNT_W-1:IDX_W] == HSEL_W'(h));

      ecc_half_acc #(.IDX_W(IDX_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .clr_i  (clr_i),
        .en_i   (en_h),
        .idx_i  (byte_cnt[IDX_W-1:0]),
        .byte_i (byte_i),
        .lp_o   (lp_w[h]),
        .cp_o   (cp_w[h])
      );

      for (genvar b = 0; b < LP_BYTES; b++) begin : g_lp_slot
        assign slot[h*SPH + b] = lp_w[h][b*BYTE_W +: BYTE_W];
      end
      assign slot[h*SPH + LP_BYTES] = {cp_w[h], 2'b11};
    end
  endgenerate

  ecc_rd_ptr #(.N_SLOTS(N_SLOTS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (clr_i),
    .adv_i (rd_adv_i),
    .ptr_o (rd_ptr)
  );

  always_comb begin
    ecc_byte_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (rd_ptr == PTR_W'(i)) ecc_byte_o = slot[i];
    end
  end
endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk #(
  parameter int unsigned N_SLOTS = 6,
  parameter int unsigned SPH     = 3,
  parameter int unsigned PTR_W   = 3,
  parameter int unsigned CNT_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             byte_vld_i,
  input logic             rd_adv_i,
  input logic [7:0]       ecc_byte_o,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [CNT_W-1:0] byte_cnt
);
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ecc_byte_o == 8'h00 && rd_ptr == '0 && byte_cnt == '0));

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr < PTR_W'(N_SLOTS));

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_i && !clr_i && rd_ptr == PTR_W'(N_SLOTS-1)) |=> rd_ptr == '0);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_i && !clr_i && rd_ptr < PTR_W'(N_SLOTS-1)) |=> rd_ptr == $past(rd_ptr) + 1'b1);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv_i && !clr_i) |=> $stable(rd_ptr));

  assert_gap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld_i && !rd_adv_i && !clr_i) |=> ($stable(ecc_byte_o) && $stable(byte_cnt)));

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !clr_i) |=> byte_cnt == CNT_W'($past(byte_cnt) + 1'b1));

  assert_cp_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_ptr) % SPH == SPH - 1) |-> ecc_byte_o[1:0] == 2'b11);
endmodule

bind nand_page_ecc nand_page_ecc_chk #(
  .N_SLOTS (N_SLOTS),
  .SPH     (SPH),
  .PTR_W   (PTR_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .byte_vld_i (byte_vld_i),
  .rd_adv_i   (rd_adv_i),
  .ecc_byte_o (ecc_byte_o),
  .rd_ptr     (rd_ptr),
  .byte_cnt   (byte_cnt)
);

// File: tb/nand_page_ecc_bench.sv
module nand_page_ecc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       rd_adv_i = 1'b0;
  logic [7:0] ecc_byte_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] sent [$];
  logic [7:0] exp6 [6];
  int mptr = 0;

  always #2 clk = ~clk;

  nand_page_ecc u_nand_page_ecc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_adv_i   (rd_adv_i),
    .ecc_byte_o (ecc_byte_o)
  );

  function automatic void chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endfunction

  // Reference ECC from the requirements (R2, R3, R4, R5, R10).
  function automatic void model();
    logic [31:0] lp;
    logic [11:0] cp;
    lp = '0;
    cp = '0;
    for (int i = 0; i < sent.size(); i++) begin
      int idx;
      int h;
      int j;
      logic [7:0] b;
      logic p;
      idx = i % 512;
      h = idx / 256;
      j = idx % 256;
      b = sent[i];
      p = ^b;
      for (int k = 0; k < 8; k++) begin
        if (((j >> k) & 1) == 1) lp[h*16 + 2*k + 1] ^= p;
        else                     lp[h*16 + 2*k]     ^= p;
      end
      cp[h*6 + 0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
      cp[h*6 + 1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
      cp[h*6 + 2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
      cp[h*6 + 3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
      cp[h*6 + 4] ^= b[0] ^ b[1] ^ b[2] ^ b[3];
      cp[h*6 + 5] ^= b[4] ^ b[5] ^ b[6] ^ b[7];
    end
    exp6[0] = lp[7:0];
    exp6[1] = lp[15:8];
    exp6[2] = {cp[5:0], 2'b11};
    exp6[3] = lp[23:16];
    exp6[4] = lp[31:24];
    exp6[5] = {cp[11:6], 2'b11};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] b);
    byte_vld_i = 1'b1;
    byte_i = b;
    sent.push_back(b);
    tick();
    byte_vld_i = 1'b0;
    byte_i = 8'h00;
  endtask

  task automatic gap(logic [7:0] junk);
    byte_vld_i = 1'b0;
    byte_i = junk;
    tick();
    byte_i = 8'h00;
  endtask

  task automatic clear(logic with_byte, logic with_read);
    clr_i = 1'b1;
    byte_vld_i = with_byte;
    byte_i = 8'hFF;
    rd_adv_i = with_read;
    sent.delete();
    mptr = 0;
    tick();
    clr_i = 1'b0;
    byte_vld_i = 1'b0;
    byte_i = 8'h00;
    rd_adv_i = 1'b0;
  endtask

  // Driver: push the expected byte, then pulse the advance strobe.
  task automatic read(string tag, int n);
    model();
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp6[mptr]);
      tag_q.push_back(tag);
      rd_adv_i = 1'b1;
      tick();
      rd_adv_i = 1'b0;
      mptr = (mptr + 1) % 6;
    end
  endtask

  // Monitor: compare the slot shown during each advance cycle.
  always @(negedge clk) begin
    if (rst_n && rd_adv_i && !clr_i) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6: actual %02h expected none (unexpected read)", ecc_byte_o);
      end else begin
        chk(tag_q.pop_front(), ecc_byte_o, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", ecc_byte_o, 8'h00);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) tick();

    read("R1 R9 reset readout", 6);
    read("R6 wrap to first", 1);
    clear(1'b0, 1'b0);

    // R11 R3: one byte at page index 0
    send(8'h01);
    read("R11 R2 R3 single byte", 6);

    // R4: one byte at page index 256 only moves the second half
    clear(1'b0, 1'b0);
    for (int i = 0; i < 256; i++) send(8'h00);
    send(8'hB7);
    read("R4 second half only", 6);

    // Full page with gaps carrying junk data (R2 R3 R5 R7)
    clear(1'b0, 1'b0);
    for (int i = 0; i < 512; i++) begin
      send(8'((i * 37 + 5) ^ (i >> 3)));
      if (i % 7 == 3) gap(8'hA5);
    end
    repeat (3) gap(8'h5A);
    read("R5 R7 full page with gaps", 7);

    // R8: clear mid readout, clear beats a byte and a read
    read("R5 partial", 2);
    clear(1'b0, 1'b1);
    read("R8 clear beats read", 1);
    send(8'h3C);
    clear(1'b1, 1'b0);
    read("R8 clear beats byte", 6);

    // R10: byte 512 folds into first half at index 0
    clear(1'b0, 1'b0);
    for (int i = 0; i < 513; i++) send(8'(i * 11 + 1));
    read("R10 count wrap", 6);

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R6: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule